// File: doc/BRIEF.md
# Station Address PROM Access Window

This block sits on a small register bus and decodes each request into one of two destinations. Requests whose address lies below 0x10 are served by a local 16-byte store that holds the station address and a few bytes of configuration. Requests at 0x10 or above go to a downstream register port that belongs to a neighbouring block. Each request carries an address, a size code, write data and a write flag. The block judges the request against the current I/O mode, and an illegal request never reaches the store or the downstream port.

Two configuration inputs are sampled on each request cycle:
- `mode_dword` selects 32-bit I/O instead of 16-bit I/O.
- `prom_wr_en` unlocks the store for writing.

Multi-byte accesses are assembled little-endian. A read answers one clock after its request, whether the data comes from the store, from the downstream port, or is the all-ones pattern for an illegal access.

Top module: `prom_window`

## Requirements
- R1: After reset, store byte i holds bits 8i+7:8i of parameter `INIT`, and `rsp_valid` is low.
- R2: Size codes are 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes. In 16-bit mode, a 1-byte read at any address below 0x10 returns the byte at index `addr[3:0]` in bits 7:0, and the upper bits are zero.
- R3: In 16-bit mode, a 2-byte access at an even address below 0x10 covers index a in bits 7:0 and index a+1 in bits 15:8. The upper 16 bits of the read data are zero.
- R4: In 16-bit mode, a 2-byte access at an odd address below 0x10 is illegal, and so is any 4-byte access below 0x10.
- R5: In 32-bit mode, the only legal access below 0x10 is a 4-byte access at an address that is a multiple of 4. It covers indices a to a+3, with index a in bits 7:0. Any 1-byte or 2-byte access below 0x10, and any misaligned 4-byte access there, is illegal.
- R6: A legal write below 0x10 changes the store only if `prom_wr_en` is high in the request cycle. Reads are unaffected by `prom_wr_en`.
- R7: An illegal read returns all ones across the access width: 0x000000FF for size 0, 0x0000FFFF for size 1, and 0xFFFFFFFF for size 2 or the reserved code 3. An illegal write changes nothing.
- R8: A request at 0x10 or above with size 1 or 2 raises `ds_valid` in the same cycle and presents the address, size, data and write flag unchanged, in either mode. For a read, the `ds_rdata` returned in the following cycle appears unchanged on `rsp_rdata`.
- R9: A request at 0x10 or above with size 0 or 3 is illegal. It is not forwarded and it follows R7.
- R10: `rsp_valid` is high exactly in the cycle after a read request, and `rsp_rdata` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| req_wdata | input | 32 | Write data, little-endian |
| mode_dword | input | 1 | 1 = 32-bit I/O mode, 0 = 16-bit I/O mode |
| prom_wr_en | input | 1 | Store write enable |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| ds_valid | output | 1 | Downstream request strobe |
| ds_write | output | 1 | Downstream write flag |
| ds_addr | output | AW | Downstream address |
| ds_size | output | 2 | Downstream size code |
| ds_wdata | output | 32 | Downstream write data |
| ds_rdata | input | 32 | Downstream read data, one cycle after the request |

## Verification
Two events can land on the same clock edge. One is the response to a downstream read. The other is a new request to the local store, which may be a write with `prom_wr_en` changing in that same cycle. The bench provokes this by issuing a forwarded read and a store write back to back, with no idle cycle between them. It then checks three things:
- The response carries the downstream data and not store data.
- The write takes effect or is dropped according to the enable level in its own cycle.
- A readback of the touched byte matches an independent model of the store.

// File: rtl/prom_window.sv
module prom_window #(
  parameter int AW = 8,
  parameter logic [127:0] INIT = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic [31:0]   req_wdata,
  input  logic          mode_dword,
  input  logic          prom_wr_en,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata,
  output logic          ds_valid,
  output logic          ds_write,
  output logic [AW-1:0] ds_addr,
  output logic [1:0]    ds_size,
  output logic [31:0]   ds_wdata,
  input  logic [31:0]   ds_rdata
);
  logic [15:0][7:0] rom;
  logic [31:0] rd_q;
  logic        from_ds_q;

  wire       upper = |req_addr[AW-1:4];
  wire [3:0] idx   = req_addr[3:0];
  wire       sz1   = req_size == 2'd0;
  wire       sz2   = req_size == 2'd1;
  wire       sz4   = req_size == 2'd2;

  wire word_ok  = sz1 || (sz2 && !idx[0]);
  wire dword_ok = sz4 && (idx[1:0] == 2'b00);
  wire prom_ok  = !upper && (mode_dword ? dword_ok : word_ok);
  wire ds_ok    = upper && (sz2 || sz4);

  wire [2:0] nbytes = sz1 ? 3'd1 : (sz2 ? 3'd2 : 3'd4);

  wire [7:0] b0 = rom[idx];
  wire [7:0] b1 = rom[idx + 4'd1];
  wire [7:0] b2 = rom[idx + 4'd2];
  wire [7:0] b3 = rom[idx + 4'd3];

  wire [31:0] prom_rd = sz1 ? {24'h0, b0} : (sz2 ? {16'h0, b1, b0} : {b3, b2, b1, b0});
  wire [31:0] ones    = sz1 ? 32'h0000_00FF : (sz2 ? 32'h0000_FFFF : 32'hFFFF_FFFF);

  wire do_read  = req_valid && !req_write;
  wire do_write = req_valid && req_write && prom_ok && prom_wr_en;

  assign ds_valid = req_valid && ds_ok;
  assign ds_write = req_write;
  assign ds_addr  = req_addr;
  assign ds_size  = req_size;
  assign ds_wdata = req_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) rom[i] <= INIT[8*i +: 8];
      rsp_valid <= 1'b0;
      rd_q      <= 32'h0;
      from_ds_q <= 1'b0;
    end else begin
      rsp_valid <= do_read;
      if (do_read) begin
        from_ds_q <= ds_ok;
        rd_q      <= prom_ok ? prom_rd : ones;
      end
      if (do_write)
        for (int k = 0; k < 4; k++)
          if (3'(k) < nbytes) rom[idx + 4'(k)] <= req_wdata[8*k +: 8];
    end
  end

  assign rsp_rdata = from_ds_q ? ds_rdata : rd_q;
endmodule

// File: rtl/prom_window_chk.sv
module prom_window_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    req_size,
  input logic          mode_dword,
  input logic          prom_wr_en,
  input logic          rsp_valid,
  input logic [31:0]   rsp_rdata,
  input logic          ds_valid,
  input logic [1:0]    ds_size,
  input logic [127:0]  prom
);
  AST_LOW_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[AW-1:4] == '0) |-> !ds_valid); // R8
  AST_DS_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ds_valid |-> (ds_size == 2'd1 || ds_size == 2'd2)); // R9
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write)); // R10
  AST_LOCKED_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !prom_wr_en) |=> $stable(prom)); // R6
  AST_DWORD_BYTE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && mode_dword && req_size == 2'd0 && req_addr[AW-1:4] == '0)
      |=> rsp_rdata == 32'h0000_00FF); // R7
endmodule

bind prom_window prom_window_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_size(req_size), .mode_dword(mode_dword),
  .prom_wr_en(prom_wr_en), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .ds_valid(ds_valid), .ds_size(ds_size), .prom(rom)
);

// File: tb/prom_window_test.sv
`timescale 1ns/1ps
module prom_window_test;
  localparam int AW = 8;
  localparam logic [127:0] INIT = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, mode_dword = 0, prom_wr_en = 0;
  logic [AW-1:0] req_addr = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_wdata = 0;
  logic rsp_valid, ds_valid, ds_write;
  logic [31:0] rsp_rdata, ds_wdata;
  logic [31:0] ds_rdata = 0;
  logic [AW-1:0] ds_addr;
  logic [1:0] ds_size;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] model [16];

  always #2 clk = ~clk;

  prom_window #(.AW(AW), .INIT(INIT)) uut (.*);

  always @(posedge clk) if (ds_valid && !ds_write) ds_rdata <= 32'hD500_0000 | 32'(ds_addr);

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit legal_low(bit m, int a, int s);
    if (a >= 16) return 0;
    if (m) return s == 2 && a % 4 == 0;
    return s == 0 || (s == 1 && a % 2 == 0);
  endfunction

  function automatic int nb(int s);
    return s == 0 ? 1 : (s == 1 ? 2 : 4);
  endfunction

  function automatic logic [31:0] exp_rd(bit m, int a, int s);
    logic [31:0] v = 0;
    if (a >= 16 && (s == 1 || s == 2)) return 32'hD500_0000 | 32'(a);
    if (legal_low(m, a, s)) begin
      for (int k = 0; k < nb(s); k++) v |= 32'(model[(a + k) & 15]) << (8 * k);
      return v;
    end
    return s == 0 ? 32'hFF : (s == 1 ? 32'hFFFF : 32'hFFFF_FFFF);
  endfunction

  task automatic access(bit w, int a, int s, logic [31:0] d, bit m, bit we, string tag);
    bit fwd = a >= 16 && (s == 1 || s == 2);
    logic [31:0] e;
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = AW'(a); req_size = 2'(s);
    req_wdata = d; mode_dword = m; prom_wr_en = we;
    #1;
    chk(ds_valid == fwd, fwd ? "R8 forward" : "R9 no forward", 32'(ds_valid), 32'(fwd));
    if (fwd)
      chk(ds_addr == AW'(a) && ds_size == 2'(s) && ds_wdata == d && ds_write == w,
          "R8 fields", 32'(ds_addr), 32'(a));
    e = exp_rd(m, a, s);
    if (w && legal_low(m, a, s) && we)
      for (int k = 0; k < nb(s); k++) model[(a + k) & 15] = d[8*k +: 8];
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid == !w, "R10 rsp_valid", 32'(rsp_valid), 32'(!w));
    if (!w) chk(rsp_rdata == e, tag, rsp_rdata, e);
  endtask

  task automatic dump_check(string tag);
    for (int i = 0; i < 16; i++) access(0, i, 0, 0, 0, 0, tag);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = INIT[8*i +: 8];
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 0, "R1 rsp_valid in reset", 32'(rsp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(rsp_valid == 0, "R1 rsp_valid idle", 32'(rsp_valid), 0);
    dump_check("R1 reset contents");

    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        for (int a = 0; a < 32; a++)
          access(0, a, s, 0, m[0], 0,
                 a >= 16 ? "R8 R9 upper read" :
                 (m == 1 ? "R5 R7 dword read" :
                 (s == 0 ? "R2 byte read" : (s == 1 ? "R3 R4 word read" : "R4 R7 word read"))));

    for (int m = 0; m < 2; m++)
      for (int we = 0; we < 2; we++)
        for (int s = 0; s < 4; s++)
          for (int a = 0; a < 20; a++) begin
            access(1, a, s, 32'hA1B2C3D4 ^ (32'(a) * 32'h01010101) ^ (32'(s) << 28),
                   m[0], we[0], "R6 write");
            dump_check(we ? "R3 R5 R7 write effect" : "R6 locked write");
          end

    // forwarded read response overlapping a store write; enable flips in that cycle
    for (int we = 0; we < 2; we++) begin
      @(negedge clk);
      req_valid = 1; req_write = 0; req_addr = 8'h14; req_size = 2'd2; mode_dword = 0; prom_wr_en = 0;
      @(negedge clk);
      req_write = 1; req_addr = 8'h03; req_size = 2'd0; req_wdata = 32'h5A + 32'(we); prom_wr_en = we[0];
      chk(rsp_valid == 1 && rsp_rdata == 32'hD500_0014, "R8 overlap rsp", rsp_rdata, 32'hD500_0014);
      if (we) model[3] = 8'h5B;
      @(negedge clk);
      req_valid = 0;
      chk(rsp_valid == 0, "R10 no rsp for write", 32'(rsp_valid), 0);
      access(0, 3, 0, 0, 0, 0, "R6 overlap write");
    end
    finish_run();
  end
endmodule